// File: doc/BRIEF.md
# Serial Interface Control Register and Shared-Pin Arbiter

This block keeps the 8-bit control word of a serial peripheral interface. It turns that word into the signals the rest of the interface needs: master or slave operation, clock idle level, clock phase, rate selection, clock-generator enable and a gated interrupt request. It also decides who owns four general-purpose port pads that the serial interface can claim: the port logic or the interface.

Software writes the control word over a single-cycle write strobe and reads it back on a parallel bus. The interrupt request combines the external transfer-complete and mode-fault flags with the interrupt enable bit and a global mask. Each pad leaves the block as a drive-enable/value pair plus an open-drain select. The shifter, the rate divider and the status flags are outside the block and reach it only as inputs.

All outputs are registered. A write, or any change on an input, shows at the outputs after the next rising clock edge, together with the new register value.

Top module: `spi_ctl_pinmux`

## Requirements
- R1: A write strobe loads `wr_data` into the control word on the next rising edge, and `rd_data` then returns it unchanged. Without a strobe the word holds. The bit meanings are: [7] interrupt enable, [6] interface enable, [5] open-drain, [4] master, [3] clock polarity, [2] clock phase, [1:0] rate select.
- R2: A synchronous reset sets the control word to 8'h04, so only the clock-phase bit is 1 and the rate bits are 0. It also clears every registered output except `clk_phase`, which follows the word and is therefore 1.
- R3: `irq` is 1 exactly when the interrupt enable bit is 1, `irq_mask` is 0, and `xfer_done` or `mode_fault` is 1.
- R4: With the interface enable bit at 0, every pad i follows the port: it is driven when `port_dir[i]` is 1 with value `port_out[i]`, and `clk_gen_en` is 0.
- R5: Pad positions are 0 data-in, 1 data-out, 2 clock, 3 select. With the interface enabled, the pads that are inputs for the chosen role are never driven and present value 0, whatever their direction bit. In master mode that is pad 0. In slave mode it is pads 0, 2 and 3.
- R6: With the interface enabled, an output-role pad (pad 1 in both modes, pad 2 in master mode) drives only when its direction bit is 1. Pad 1 carries `shift_dout` and pad 2 carries `shift_sck`.
- R7: In master mode with the interface enabled, a select-pad direction bit of 0 sets `fault_det_en` to 1 and leaves pad 3 undriven. A direction bit of 1 clears `fault_det_en` and makes pad 3 a plain output that carries `port_out[3]`.
- R8: With the open-drain bit at 1, all four `pad_od` bits are 1, `pad_val` is 0, and a pad that would drive is enabled only when its data is 0. With the bit at 0, `pad_od` is 0 and the pads are push-pull.
- R9: `clk_idle_hi` equals the polarity bit, `master_mode` equals the master bit, `clk_phase` equals the phase bit and `rate_sel` equals the rate bits.
- R10: `clk_gen_en` equals the interface enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Control word read-back |
| xfer_done | input | 1 | Transfer-complete flag |
| mode_fault | input | 1 | Mode-fault flag |
| irq_mask | input | 1 | Global interrupt mask, 1 blocks requests |
| port_dir | input | 4 | Port direction bits, 1 = output |
| port_out | input | 4 | Port output data |
| shift_dout | input | 1 | Serial data from the shifter |
| shift_sck | input | 1 | Serial clock from the generator |
| pad_oe | output | 4 | Pad drive enables |
| pad_val | output | 4 | Pad drive values |
| pad_od | output | 4 | Pad open-drain selects |
| clk_idle_hi | output | 1 | Clock idle level |
| clk_phase | output | 1 | Clock phase select |
| rate_sel | output | 2 | Rate select |
| master_mode | output | 1 | 1 = master |
| clk_gen_en | output | 1 | Clock generator enable |
| fault_det_en | output | 1 | Select pad acts as fault input |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives each direction bit against each role of each pad. A design that honoured the direction bit on an input-role pad would drive a pad that an external device also drives. A design that ignored the direction bit on an output-role pad would drive a pad that software left as an input. The select pad is checked in both master sub-cases and in slave mode, where a wrong design would raise the fault detector or drive the pad. The bench also checks open-drain against data 1 and data 0, the interrupt gate under the mask with each flag alone, and the read-back after reset, where a wrong reset would not show 8'h04.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  localparam int REG_W   = 8;
  localparam int NPADS   = 4;
  localparam int RATE_W  = 2;
  localparam logic [REG_W-1:0] CTRL_RST = 8'h04;

  localparam int B_IE   = 7;
  localparam int B_EN   = 6;
  localparam int B_OD   = 5;
  localparam int B_MST  = 4;
  localparam int B_POL  = 3;
  localparam int B_PHA  = 2;
  localparam int B_RATE = 0;

  localparam int PAD_DIN  = 0;
  localparam int PAD_DOUT = 1;
  localparam int PAD_CLK  = 2;
  localparam int PAD_SEL  = 3;

  typedef enum logic [1:0] {ROLE_IN, ROLE_OUT, ROLE_SEL} pad_role_e;

  function automatic pad_role_e role_of(input int idx, input logic master);
    pad_role_e r;
    r = ROLE_IN;
    if (idx == PAD_DOUT) r = ROLE_OUT;
    else if (idx == PAD_CLK) r = master ? ROLE_OUT : ROLE_IN;
    else if (idx == PAD_SEL) r = master ? ROLE_SEL : ROLE_IN;
    return r;
  endfunction
endpackage

// File: rtl/spi_ctl_reg.sv
module spi_ctl_reg
  import spi_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] ctrl_q,
  output logic [REG_W-1:0] ctrl_nxt
);
  assign ctrl_nxt = wr_en ? wr_data : ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= CTRL_RST;
    else     ctrl_q <= ctrl_nxt;
  end

  // R2
  a_r2_reset_word: assert property (@(posedge clk) rst |=> ctrl_q == CTRL_RST);
  // R1
  a_r1_write_lands: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ctrl_q == $past(wr_data));
  a_r1_hold_word: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(ctrl_q));
endmodule

// File: rtl/spi_ctl_irq.sv
module spi_ctl_irq (
  input  logic clk,
  input  logic rst,
  input  logic irq_en,
  input  logic irq_mask,
  input  logic xfer_done,
  input  logic mode_fault,
  output logic irq_q
);
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= irq_en & ~irq_mask & (xfer_done | mode_fault);
  end

  // R3
  a_r3_mask_blocks: assert property (@(posedge clk) disable iff (rst)
    (irq_mask || !irq_en) |=> !irq_q);
  a_r3_flag_raises: assert property (@(posedge clk) disable iff (rst)
    (irq_en && !irq_mask && (xfer_done || mode_fault)) |=> irq_q);
endmodule

// File: rtl/spi_pin_cell.sv
module spi_pin_cell
  import spi_ctl_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic master,
  input  logic open_drain,
  input  logic dir,
  input  logic gpio_val,
  input  logic spi_val,
  output logic oe_q,
  output logic val_q,
  output logic od_q
);
  pad_role_e role;
  logic      drv, dat;

  always_comb begin
    role = role_of(IDX, master);
    drv  = 1'b0;
    dat  = 1'b0;
    if (!enable) begin
      drv = dir;
      dat = gpio_val;
    end else begin
      unique case (role)
        ROLE_OUT: begin drv = dir; dat = spi_val;  end
        ROLE_SEL: begin drv = dir; dat = gpio_val; end
        default:  begin drv = 1'b0; dat = 1'b0;    end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q  <= 1'b0;
      val_q <= 1'b0;
      od_q  <= 1'b0;
    end else begin
      oe_q  <= drv & (~open_drain | ~dat);
      val_q <= dat & ~open_drain;
      od_q  <= open_drain;
    end
  end

  // R5
  a_r5_input_undriven: assert property (@(posedge clk) disable iff (rst)
    (enable && role == ROLE_IN) |=> !oe_q);
  // R6
  a_r6_dir_gates_drive: assert property (@(posedge clk) disable iff (rst)
    !dir |=> !oe_q);
  // R8
  a_r8_od_low_only: assert property (@(posedge clk) disable iff (rst)
    od_q |-> !val_q);
endmodule

// File: rtl/spi_ctl_pinmux.sv
module spi_ctl_pinmux
  import spi_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  input  logic              xfer_done,
  input  logic              mode_fault,
  input  logic              irq_mask,
  input  logic [NPADS-1:0]  port_dir,
  input  logic [NPADS-1:0]  port_out,
  input  logic              shift_dout,
  input  logic              shift_sck,
  output logic [NPADS-1:0]  pad_oe,
  output logic [NPADS-1:0]  pad_val,
  output logic [NPADS-1:0]  pad_od,
  output logic              clk_idle_hi,
  output logic              clk_phase,
  output logic [RATE_W-1:0] rate_sel,
  output logic              master_mode,
  output logic              clk_gen_en,
  output logic              fault_det_en,
  output logic              irq
);
  logic [REG_W-1:0] ctrl_q, ctrl_nxt;
  logic [NPADS-1:0] spi_vals;
  logic             n_en, n_mst, n_od;

  spi_ctl_reg u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .ctrl_nxt(ctrl_nxt)
  );
  assign rd_data = ctrl_q;

  assign n_en  = ctrl_nxt[B_EN];
  assign n_mst = ctrl_nxt[B_MST];
  assign n_od  = ctrl_nxt[B_OD];

  spi_ctl_irq u_irq (
    .clk(clk), .rst(rst), .irq_en(ctrl_nxt[B_IE]), .irq_mask(irq_mask),
    .xfer_done(xfer_done), .mode_fault(mode_fault), .irq_q(irq)
  );

  always_comb begin
    spi_vals           = '0;
    spi_vals[PAD_DOUT] = shift_dout;
    spi_vals[PAD_CLK]  = shift_sck;
  end

  for (genvar i = 0; i < NPADS; i++) begin : g_pad
    spi_pin_cell #(.IDX(i)) u_cell (
      .clk(clk), .rst(rst), .enable(n_en), .master(n_mst),
      .open_drain(n_od), .dir(port_dir[i]), .gpio_val(port_out[i]),
      .spi_val(spi_vals[i]), .oe_q(pad_oe[i]), .val_q(pad_val[i]),
      .od_q(pad_od[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_idle_hi  <= 1'b0;
      clk_phase    <= CTRL_RST[B_PHA];
      rate_sel     <= '0;
      master_mode  <= 1'b0;
      clk_gen_en   <= 1'b0;
      fault_det_en <= 1'b0;
    end else begin
      clk_idle_hi  <= ctrl_nxt[B_POL];
      clk_phase    <= ctrl_nxt[B_PHA];
      rate_sel     <= ctrl_nxt[B_RATE +: RATE_W];
      master_mode  <= n_mst;
      clk_gen_en   <= n_en;
      fault_det_en <= n_en & n_mst & ~port_dir[PAD_SEL];
    end
  end

  // R7
  a_r7_fault_pad_idle: assert property (@(posedge clk) disable iff (rst)
    fault_det_en |-> !pad_oe[PAD_SEL]);
  // R10
  a_r10_gen_matches_word: assert property (@(posedge clk) disable iff (rst)
    clk_gen_en == rd_data[B_EN]);
  // R9
  a_r9_idle_matches_word: assert property (@(posedge clk) disable iff (rst)
    clk_idle_hi == rd_data[B_POL]);
endmodule

// File: tb/test_spi_ctl_pinmux.sv
module test_spi_ctl_pinmux;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst = 1, wr_en = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic       xfer_done = 0, mode_fault = 0, irq_mask = 0;
  logic [3:0] port_dir = 0, port_out = 0;
  logic       shift_dout = 0, shift_sck = 0;
  logic [3:0] pad_oe, pad_val, pad_od;
  logic       clk_idle_hi, clk_phase, master_mode, clk_gen_en, fault_det_en, irq;
  logic [1:0] rate_sel;

  spi_ctl_pinmux i_spi_ctl_pinmux (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] mreg;
  logic [27:0] exp_q[$];
  string       tag_q[$];

  function automatic logic [27:0] actual();
    return {rd_data, pad_oe, pad_val, pad_od, irq, clk_idle_hi, master_mode,
            clk_phase, rate_sel, clk_gen_en, fault_det_en};
  endfunction

  task automatic check(input logic [27:0] exp, input string tag);
    n_vec++;
    if (actual() !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, actual(), exp);
    end
  endtask

  // Expected outputs from the requirements
  task automatic apply(input logic wr, input logic [7:0] wd, input logic msk,
                       input logic dn, input logic flt, input logic [3:0] dir,
                       input logic [3:0] gp, input logic sdo, input logic sck,
                       input string tag);
    logic [3:0] drv, d, oe, val;
    logic en, mst, od, ie, fdet, ir;
    @(negedge clk);
    wr_en = wr; wr_data = wd; irq_mask = msk; xfer_done = dn; mode_fault = flt;
    port_dir = dir; port_out = gp; shift_dout = sdo; shift_sck = sck;
    if (wr) mreg = wd;
    ie = mreg[7]; en = mreg[6]; od = mreg[5]; mst = mreg[4];
    drv = 0; d = 0;
    if (!en) begin drv = dir; d = gp; end
    else begin
      drv[1] = dir[1]; d[1] = sdo;
      if (mst) begin
        drv[2] = dir[2]; d[2] = sck;
        drv[3] = dir[3]; d[3] = gp[3];
      end
    end
    oe  = drv & (~{4{od}} | ~d);
    val = od ? 4'b0 : d;
    fdet = en & mst & ~dir[3];
    ir = ie & ~msk & (dn | flt);
    exp_q.push_back({mreg, oe, val, {4{od}}, ir, mreg[3], mst, mreg[2],
                     mreg[1:0], en, fdet});
    tag_q.push_back(tag);
  endtask

  // Monitor: compare one result per edge
  initial begin
    forever begin
      @(posedge clk); #1;
      if (exp_q.size() > 0) check(exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_bad++; n_vec++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    mreg = 8'h04;
    repeat (3) @(negedge clk);
    // R2 reset state
    check({8'h04, 4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0}, "R2 reset");
    rst = 0;
    // R4 disabled: pads follow the port
    apply(0, 0, 0, 0, 0, 4'b1010, 4'b1110, 1, 1, "R4 gpio pass");
    apply(0, 0, 0, 0, 0, 4'b0101, 4'b0101, 0, 0, "R4 gpio pass 2");
    // R1 write and read-back, R9 decode
    apply(1, 8'h0B, 0, 0, 0, 4'b0000, 4'b0000, 0, 0, "R1 R9 write 0B");
    apply(0, 8'hFF, 0, 0, 0, 4'b0000, 4'b0000, 0, 0, "R1 hold without strobe");
    // R5/R6/R7/R10 master enabled, select pad dir 0
    apply(1, 8'h5A, 0, 0, 0, 4'b0111, 4'b1111, 1, 0, "R5 R6 R7 R10 master fault");
    apply(0, 0, 0, 0, 0, 4'b1111, 4'b0110, 0, 1, "R7 select pad output");
    apply(0, 0, 0, 0, 0, 4'b1001, 4'b1111, 1, 1, "R6 dir gates outputs");
    // slave mode
    apply(1, 8'h44, 0, 0, 0, 4'b1111, 4'b1111, 1, 1, "R5 slave inputs undriven");
    apply(0, 0, 0, 0, 0, 4'b0000, 4'b1111, 1, 1, "R6 slave dout dir0");
    // R8 open-drain
    apply(1, 8'h70, 0, 0, 0, 4'b1111, 4'b1111, 1, 0, "R8 od master");
    apply(0, 0, 0, 0, 0, 4'b1111, 4'b0000, 0, 1, "R8 od zeros");
    apply(1, 8'h20, 0, 0, 0, 4'b1111, 4'b0101, 0, 0, "R8 od gpio");
    // R3 interrupt gate
    apply(1, 8'h80, 0, 1, 0, 0, 0, 0, 0, "R3 done");
    apply(0, 0, 0, 0, 1, 0, 0, 0, 0, "R3 fault");
    apply(0, 0, 1, 1, 1, 0, 0, 0, 0, "R3 masked");
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0, "R3 no flag");
    apply(1, 8'h00, 0, 1, 1, 0, 0, 0, 0, "R3 ie off");
    apply(1, 8'hCF, 0, 1, 0, 4'b1111, 4'b1010, 1, 1, "R3 R9 R5 slave ie");
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 idle");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule